// File: doc/BRIEF.md
# Dual-Identity Two-Wire Serial Slave

This block is the slave side of a two-wire (I2C-style) serial bus. A system clock samples the SCL and SDA lines, and the block watches them for start and stop conditions. The first byte after a start is an identity byte. It can select one of two logical devices behind one bus slot: a byte-wide memory, or a small companion register bank. The block answers only when the two device-select bits in that byte match its select pins.

A write transaction carries two pointer bytes, high byte first, followed by any number of data bytes. The block acknowledges every byte and turns each data byte into a one-cycle write strobe on the selected port. A read transaction streams bytes from the current pointer for as long as the master acknowledges. The pointer advances after every byte and wraps at the size of the selected space.

Three events end any operation in progress: a start, a stop, or the low-voltage input. The SDA output is open-drain: the block either pulls the line low or releases it.

Top module: `tw_dual_slave`

## Requirements
- R1: After reset the block does not drive SDA and raises no strobe. SDA falling while SCL is high is a start and opens reception of an identity byte. SDA rising while SCL is high is a stop and closes the transaction.
- R2: The block acknowledges an identity byte by pulling SDA low during the ninth clock. It does so when bits 7-4 are 1010 (memory) or 1101 (companion) and bits 2-1 equal `dev_sel_i`. Bit 3 is ignored. Bit 0 set means read and bit 0 clear means write.
- R3: An identity byte that does not match is not acknowledged. Bytes that follow it without a new start are not acknowledged either, and they cause no strobe.
- R4: In a write, the two bytes after the identity form the pointer, high byte first. Bits above MEM_AW are dropped. Each later data byte is acknowledged and produces a one-cycle `mem_we` with the pointer and the byte.
- R5: The pointer advances by one after each data byte written or read. It wraps from the top of the MEM_AW space (or the REG_AW space for the companion) to zero.
- R6: A companion transaction uses only the `reg_*` port, with its pointer masked to REG_AW bits. It never raises `mem_we` or `mem_re`.
- R7: In a read, the block shifts out bytes MSB first, each fetched with a `*_re` strobe. It continues while the master pulls SDA low in the ninth clock. After a master NACK it releases SDA and drives nothing more.
- R8: A start inside a byte or an operation abandons that operation. The byte that follows is decoded as a new identity byte.
- R9: A stop inside a byte abandons the operation without a strobe. Later bytes with no new start are not acknowledged.
- R10: Raising `lowv_i` releases SDA and suppresses strobes from the next cycle on. The block ignores the bus until a start condition occurs after `lowv_i` has dropped.
- R11: SDA begins to be driven only while SCL is low. Every write strobe lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as sampled |
| sda_i | input | 1 | Serial data line as sampled |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| dev_sel_i | input | 2 | Device-select strap compared with identity bits 2-1 |
| lowv_i | input | 1 | Low-voltage abort, active high |
| mem_addr | output | MEM_AW | Memory pointer |
| mem_wdata | output | 8 | Memory write byte |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe, data expected the next cycle |
| mem_rdata | input | 8 | Memory read byte |
| reg_addr | output | REG_AW | Companion register pointer |
| reg_wdata | output | 8 | Companion write byte |
| reg_we | output | 1 | Companion write strobe |
| reg_re | output | 1 | Companion read strobe, data expected the next cycle |
| reg_rdata | input | 8 | Companion read byte |

## Verification
Each line passes through two synchronizer flops and one edge register. A write strobe therefore appears in the third clock cycle after the SCL fall that ends the eighth bit. The acknowledge pull-down appears in that same cycle. The bench holds each SCL phase for twenty cycles and samples SDA in the middle of the high phase, so every result has settled by the time it is read. A read fetch is issued three cycles after the acknowledge clock rises, and its byte is driven three cycles after that clock falls. The low-voltage release is due one cycle after `lowv_i` rises, and the bench checks it two cycles later. Write strobes are compared by a scoreboard monitor at the falling clock edge, in the order the driver queued them.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEVID,
    ST_ADRH,
    ST_ADRL,
    ST_WDAT,
    ST_RDAT
  } tw_state_e;
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/tw_id_decode.sv
module tw_id_decode #(
  parameter logic [3:0] MEM_ID = 4'b1010,
  parameter logic [3:0] CMP_ID = 4'b1101
) (
  input  logic [3:0] id_i,
  input  logic [1:0] sel_i,
  input  logic [1:0] dev_sel_i,
  output logic       hit_mem_o,
  output logic       hit_cmp_o
);
  logic sel_ok;
  assign sel_ok    = (sel_i == dev_sel_i);
  assign hit_mem_o = sel_ok && (id_i == MEM_ID);
  assign hit_cmp_o = sel_ok && (id_i == CMP_ID);
endmodule

// File: rtl/tw_ctrl.sv
module tw_ctrl
  import tw_pkg::*;
#(
  parameter int         MEM_AW = 11,
  parameter int         REG_AW = 5,
  parameter logic [3:0] MEM_ID = 4'b1010,
  parameter logic [3:0] CMP_ID = 4'b1101
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              lowv_i,
  input  logic [1:0]        dev_sel_i,
  input  logic [7:0]        mem_rdata,
  input  logic [7:0]        reg_rdata,
  output logic              sda_oe,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [REG_AW-1:0] reg_addr,
  output logic [7:0]        wdata,
  output logic              mem_we,
  output logic              mem_re,
  output logic              reg_we,
  output logic              reg_re
);
  localparam int PW = (MEM_AW > REG_AW) ? MEM_AW : REG_AW;
  localparam logic [15:0] MEM_MASK = 16'((17'd1 << MEM_AW) - 17'd1);
  localparam logic [15:0] REG_MASK = 16'((17'd1 << REG_AW) - 17'd1);

  tw_state_e   st;
  logic [3:0]  bitc;
  logic [7:0]  shreg, txbyte, adr_hi;
  logic [PW-1:0] ptr, ptr_inc;
  logic [15:0] mask_sel;
  logic [2:0]  bidx;
  logic        ack_smp, to_cmp, rd_pend, bump;
  logic        hit_mem, hit_cmp;

  tw_id_decode #(.MEM_ID(MEM_ID), .CMP_ID(CMP_ID)) u_dec (
    .id_i      (shreg[7:4]),
    .sel_i     (shreg[2:1]),
    .dev_sel_i (dev_sel_i),
    .hit_mem_o (hit_mem),
    .hit_cmp_o (hit_cmp)
  );

  assign mask_sel = to_cmp ? REG_MASK : MEM_MASK;
  assign ptr_inc  = PW'((16'(ptr) + 16'd1) & mask_sel);
  assign bidx     = 3'(4'd7 - bitc);
  assign mem_addr = ptr[MEM_AW-1:0];
  assign reg_addr = ptr[REG_AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;
      bitc <= '0;
      shreg <= '0;
      txbyte <= '0;
      adr_hi <= '0;
      ptr <= '0;
      wdata <= '0;
      ack_smp <= 1'b1;
      to_cmp <= 1'b0;
      rd_pend <= 1'b0;
      bump <= 1'b0;
      sda_oe <= 1'b0;
      mem_we <= 1'b0;
      mem_re <= 1'b0;
      reg_we <= 1'b0;
      reg_re <= 1'b0;
    end else begin
      mem_we  <= 1'b0;
      reg_we  <= 1'b0;
      mem_re  <= 1'b0;
      reg_re  <= 1'b0;
      rd_pend <= mem_re | reg_re;
      bump    <= mem_we | reg_we | mem_re | reg_re;
      if (rd_pend) txbyte <= to_cmp ? reg_rdata : mem_rdata;
      if (bump) ptr <= ptr_inc;

      if (lowv_i) begin
        st <= ST_IDLE;
        sda_oe <= 1'b0;
        bitc <= '0;
      end else if (start_det) begin
        st <= ST_DEVID;
        sda_oe <= 1'b0;
        bitc <= '0;
      end else if (stop_det) begin
        st <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (st != ST_IDLE) begin
        if (scl_rise) begin
          if (bitc < 4'd8) begin
            shreg <= {shreg[6:0], sda_s};
            bitc  <= bitc + 4'd1;
          end else if (bitc == 4'd8) begin
            ack_smp <= sda_s;
            bitc    <= 4'd9;
            if (st == ST_RDAT && !sda_s) begin
              mem_re <= !to_cmp;
              reg_re <= to_cmp;
            end
          end
        end else if (scl_fall) begin
          if (bitc == 4'd8) begin
            unique case (st)
              ST_DEVID: begin
                if (hit_mem || hit_cmp) begin
                  sda_oe <= 1'b1;
                  to_cmp <= hit_cmp;
                  st     <= shreg[0] ? ST_RDAT : ST_ADRH;
                end else begin
                  st <= ST_IDLE;
                end
              end
              ST_ADRH: begin
                adr_hi <= shreg;
                sda_oe <= 1'b1;
                st     <= ST_ADRL;
              end
              ST_ADRL: begin
                ptr    <= PW'({adr_hi, shreg} & mask_sel);
                sda_oe <= 1'b1;
                st     <= ST_WDAT;
              end
              ST_WDAT: begin
                mem_we <= !to_cmp;
                reg_we <= to_cmp;
                wdata  <= shreg;
                sda_oe <= 1'b1;
              end
              ST_RDAT: sda_oe <= 1'b0;
              default: sda_oe <= 1'b0;
            endcase
          end else if (bitc == 4'd9) begin
            bitc <= '0;
            if (st == ST_RDAT && !ack_smp) begin
              sda_oe <= !txbyte[7];
            end else begin
              sda_oe <= 1'b0;
              if (st == ST_RDAT) st <= ST_IDLE;
            end
          end else if (st == ST_RDAT && bitc != 4'd0) begin
            sda_oe <= !txbyte[bidx];
          end
        end
      end
    end
  end
endmodule

// File: rtl/tw_dual_slave.sv
module tw_dual_slave #(
  parameter int         MEM_AW      = 11,
  parameter int         REG_AW      = 5,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] MEM_ID      = 4'b1010,
  parameter logic [3:0] CMP_ID      = 4'b1101
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [1:0]        dev_sel_i,
  input  logic              lowv_i,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [7:0]        mem_rdata,
  output logic [REG_AW-1:0] reg_addr,
  output logic [7:0]        reg_wdata,
  output logic              reg_we,
  output logic              reg_re,
  input  logic [7:0]        reg_rdata
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0] wdata;

  tw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  tw_ctrl #(
    .MEM_AW (MEM_AW),
    .REG_AW (REG_AW),
    .MEM_ID (MEM_ID),
    .CMP_ID (CMP_ID)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .lowv_i    (lowv_i),
    .dev_sel_i (dev_sel_i),
    .mem_rdata (mem_rdata),
    .reg_rdata (reg_rdata),
    .sda_oe    (sda_oe),
    .mem_addr  (mem_addr),
    .reg_addr  (reg_addr),
    .wdata     (wdata),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .reg_we    (reg_we),
    .reg_re    (reg_re)
  );

  assign mem_wdata = wdata;
  assign reg_wdata = wdata;
endmodule

// File: rtl/tw_dual_slave_chk.sv
module tw_dual_slave_chk (
  input logic clk,
  input logic rst,
  input logic scl_i,
  input logic lowv_i,
  input logic sda_oe,
  input logic mem_we,
  input logic mem_re,
  input logic reg_we,
  input logic reg_re
);
  // R10
  lowv_release_chk: assert property (@(posedge clk) disable iff (rst)
    lowv_i |=> !sda_oe);

  // R10
  lowv_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    lowv_i |=> !(mem_we || reg_we));

  // R11
  drive_on_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_i);

  // R11
  mem_we_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  // R11
  reg_we_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);

  // R6
  port_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we || reg_re) |-> !(mem_we || mem_re));

  // R4
  wr_rd_excl_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !mem_re);
endmodule

bind tw_dual_slave tw_dual_slave_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .scl_i  (scl_i),
  .lowv_i (lowv_i),
  .sda_oe (sda_oe),
  .mem_we (mem_we),
  .mem_re (mem_re),
  .reg_we (reg_we),
  .reg_re (reg_re)
);

// File: tb/tb_tw_dual_slave.sv
module tb_tw_dual_slave;
  localparam int MEM_AW = 11;
  localparam int REG_AW = 5;
  localparam int MEM_D  = 1 << MEM_AW;
  localparam int REG_D  = 1 << REG_AW;
  localparam int Q      = 10;

  typedef struct packed {
    logic        is_reg;
    logic [15:0] addr;
    logic [7:0]  data;
  } wr_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1, lowv = 1'b0;
  logic sda_oe, mem_we, mem_re, reg_we, reg_re;
  logic [MEM_AW-1:0] mem_addr;
  logic [REG_AW-1:0] reg_addr;
  logic [7:0] mem_wdata, reg_wdata;
  logic [7:0] mem_rdata = '0, reg_rdata = '0;
  logic sda_line;
  logic [7:0] mem_m [0:MEM_D-1];
  logic [7:0] reg_m [0:REG_D-1];
  wr_t exp_q[$];
  int nchk = 0, nerr = 0;

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  tw_dual_slave #(.MEM_AW(MEM_AW), .REG_AW(REG_AW)) dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .dev_sel_i(2'b10), .lowv_i(lowv),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
    .reg_rdata(reg_rdata)
  );

  task automatic check_eq(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory and register models, read data registered one cycle after the strobe
  always @(posedge clk) begin
    if (mem_re) mem_rdata <= mem_m[mem_addr];
    if (reg_re) reg_rdata <= reg_m[reg_addr];
  end

  // scoreboard monitor for write strobes (R4 R5 R6)
  always @(negedge clk) begin
    if (!rst && (mem_we || reg_we)) begin
      wr_t got, e;
      got.is_reg = reg_we;
      got.addr   = reg_we ? 16'(reg_addr) : 16'(mem_addr);
      got.data   = reg_we ? reg_wdata : mem_wdata;
      if (exp_q.size() == 0) begin
        check_eq("R3 R9 unexpected write", int'(got), -1);
      end else begin
        e = exp_q.pop_front();
        check_eq("R4 R5 R6 write item", int'(got), int'(e));
      end
      if (reg_we) reg_m[reg_addr] = reg_wdata;
      else mem_m[mem_addr] = mem_wdata;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_wr(input logic is_reg, input int addr, input logic [7:0] d);
    wr_t w;
    w.is_reg = is_reg;
    w.addr = 16'(addr);
    w.data = d;
    exp_q.push_back(w);
  endtask

  task automatic clk_bit(input logic v);
    sda_m = v; wait_n(Q);
    scl_m = 1'b1; wait_n(2*Q);
    scl_m = 1'b0; wait_n(Q);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_n(Q);
    scl_m = 1'b1; wait_n(Q);
    sda_m = 1'b0; wait_n(Q);
    scl_m = 1'b0; wait_n(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_n(Q);
    scl_m = 1'b1; wait_n(Q);
    sda_m = 1'b1; wait_n(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) clk_bit(b[i]);
    sda_m = 1'b1; wait_n(Q);
    scl_m = 1'b1; wait_n(Q);
    ack = sda_line; wait_n(Q);
    scl_m = 1'b0; wait_n(Q);
  endtask

  task automatic send_chk(input logic [7:0] b, input logic exp_ack, input string tag);
    logic a;
    send_byte(b, a);
    check_eq(tag, int'(a), int'(exp_ack));
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      wait_n(Q); scl_m = 1'b1; wait_n(Q);
      b = {b[6:0], sda_line};
      wait_n(Q); scl_m = 1'b0;
    end
    wait_n(Q);
    sda_m = !give_ack; wait_n(Q);
    scl_m = 1'b1; wait_n(2*Q);
    scl_m = 1'b0; wait_n(Q);
    sda_m = 1'b1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] rb;
    for (int i = 0; i < MEM_D; i++) mem_m[i] = 8'(i * 7 + 3);
    for (int i = 0; i < REG_D; i++) reg_m[i] = 8'(i * 5 + 1);
    wait_n(5);
    rst = 1'b0;
    wait_n(5);
    // R1 reset state
    check_eq("R1 reset sda_oe", int'(sda_oe), 0);
    check_eq("R1 reset strobes", int'({mem_we, mem_re, reg_we, reg_re}), 0);

    // R2 R4: write, upper pointer bits dropped (0x1234 -> 0x234)
    bus_start();
    send_chk(8'hA4, 1'b0, "R2 memory identity ack");
    send_chk(8'h12, 1'b0, "R4 pointer high ack");
    send_chk(8'h34, 1'b0, "R4 pointer low ack");
    expect_wr(1'b0, 'h234, 8'h5A);
    expect_wr(1'b0, 'h235, 8'hC3);
    send_chk(8'h5A, 1'b0, "R4 data ack");
    send_chk(8'hC3, 1'b0, "R5 second data ack");
    bus_stop();
    wait_n(Q);
    check_eq("R1 R4 writes drained", exp_q.size(), 0);

    // R2 bit 3 is don't care
    bus_start();
    send_chk(8'hAC, 1'b0, "R2 bit3 set ack");
    send_chk(8'h01, 1'b0, "R2 ptr high");
    send_chk(8'h00, 1'b0, "R2 ptr low");
    expect_wr(1'b0, 'h100, 8'h66);
    send_chk(8'h66, 1'b0, "R2 data");
    bus_stop();

    // R3 wrong select and wrong identity
    bus_start();
    send_chk(8'hA2, 1'b1, "R3 wrong select nack");
    send_chk(8'h00, 1'b1, "R3 following byte nack");
    bus_stop();
    bus_start();
    send_chk(8'hB4, 1'b1, "R3 wrong identity nack");
    bus_stop();

    // R5 wrap at top of memory space
    bus_start();
    send_chk(8'hA4, 1'b0, "R5 id");
    send_chk(8'h07, 1'b0, "R5 ptr high");
    send_chk(8'hFF, 1'b0, "R5 ptr low");
    expect_wr(1'b0, 'h7FF, 8'h01);
    expect_wr(1'b0, 'h000, 8'h02);
    send_chk(8'h01, 1'b0, "R5 data top");
    send_chk(8'h02, 1'b0, "R5 data wrapped");
    bus_stop();

    // R7 sequential read from 0x234
    bus_start();
    send_chk(8'hA4, 1'b0, "R7 id");
    send_chk(8'h12, 1'b0, "R7 ptr high");
    send_chk(8'h34, 1'b0, "R7 ptr low");
    bus_start();
    send_chk(8'hA5, 1'b0, "R7 read identity ack");
    recv_byte(1'b1, rb);
    check_eq("R7 read byte 0", int'(rb), 'h5A);
    recv_byte(1'b1, rb);
    check_eq("R7 R5 read byte 1", int'(rb), 'hC3);
    recv_byte(1'b0, rb);
    check_eq("R7 R5 read byte 2", int'(rb), int'(mem_m['h236]));
    wait_n(Q);
    check_eq("R7 released after nack", int'(sda_oe), 0);
    bus_stop();

    // R6 companion write with pointer masked to 5 bits, then read back
    bus_start();
    send_chk(8'hD4, 1'b0, "R6 companion ack");
    send_chk(8'h00, 1'b0, "R6 ptr high");
    send_chk(8'h23, 1'b0, "R6 ptr low");
    expect_wr(1'b1, 'h03, 8'h77);
    send_chk(8'h77, 1'b0, "R6 data");
    bus_stop();
    bus_start();
    send_chk(8'hD4, 1'b0, "R6 id");
    send_chk(8'h00, 1'b0, "R6 ptr high");
    send_chk(8'h03, 1'b0, "R6 ptr low");
    bus_start();
    send_chk(8'hD5, 1'b0, "R6 read id");
    recv_byte(1'b0, rb);
    check_eq("R6 companion read", int'(rb), 'h77);
    bus_stop();

    // R8 start inside a data byte
    bus_start();
    send_chk(8'hA4, 1'b0, "R8 id");
    send_chk(8'h00, 1'b0, "R8 ptr high");
    send_chk(8'h10, 1'b0, "R8 ptr low");
    clk_bit(1'b1); clk_bit(1'b0); clk_bit(1'b1); clk_bit(1'b0);
    bus_start();
    send_chk(8'hA4, 1'b0, "R8 new identity after abort");
    send_chk(8'h00, 1'b0, "R8 ptr high");
    send_chk(8'h20, 1'b0, "R8 ptr low");
    expect_wr(1'b0, 'h020, 8'h11);
    send_chk(8'h11, 1'b0, "R8 data");
    bus_stop();

    // R9 stop inside a data byte
    bus_start();
    send_chk(8'hA4, 1'b0, "R9 id");
    send_chk(8'h00, 1'b0, "R9 ptr high");
    send_chk(8'h50, 1'b0, "R9 ptr low");
    clk_bit(1'b1); clk_bit(1'b1); clk_bit(1'b0);
    bus_stop();
    send_chk(8'h99, 1'b1, "R9 byte after stop nack");
    bus_stop();
    check_eq("R9 no write after stop", exp_q.size(), 0);

    // R10 low-voltage abort during a read
    bus_start();
    send_chk(8'hA4, 1'b0, "R10 id");
    send_chk(8'h03, 1'b0, "R10 ptr high");
    send_chk(8'h00, 1'b0, "R10 ptr low");
    expect_wr(1'b0, 'h300, 8'h00);
    send_chk(8'h00, 1'b0, "R10 data zero");
    bus_start();
    send_chk(8'hA4, 1'b0, "R10 id");
    send_chk(8'h03, 1'b0, "R10 ptr high");
    send_chk(8'h00, 1'b0, "R10 ptr low");
    bus_start();
    send_chk(8'hA5, 1'b0, "R10 read id");
    clk_bit(1'b1); clk_bit(1'b1);
    check_eq("R7 driving zero bit", int'(sda_oe), 1);
    lowv = 1'b1;
    wait_n(2);
    check_eq("R10 released on low voltage", int'(sda_oe), 0);
    wait_n(Q);
    lowv = 1'b0;
    send_chk(8'hA4, 1'b1, "R10 bus ignored without start");
    bus_stop();
    bus_start();
    send_chk(8'hA4, 1'b0, "R10 answers after new start");
    bus_stop();

    wait_n(Q);
    check_eq("R4 pending writes", exp_q.size(), 0);
    finish_run();
  end
endmodule